// File: doc/BRIEF.md
# Two-Line Pulse Bit Transmitter

This block sends a bit message of up to 64 bits over a pair of active-low lines in the Wiegand style. One line carries zero bits and the other carries one bits. Each bit appears as a single low pulse on the line that matches its value. A gap with both lines high separates consecutive pulses.

Software uses a small single-beat register port to load a 64-bit data word as two 32-bit halves. It then programs the pulse width, the inter-pulse gap and the message length. A transfer starts when the length register is written with its start flag set. A status register reports whether a transfer is still running. The sequencer takes a private copy of the data and timing values when a transfer starts, so software may reprogram the registers for the next message while the current one is still being sent.

Top module: `wgd_pulse_tx`

## Requirements
- R1: After reset, both lines are high, the busy flag (address 5, bit 0) reads 0, the width register (address 2) reads 4 and the gap register (address 3) reads 9.
- R2: Each message bit is sent as exactly one low pulse on the zero line (`tx_zero_n`) for a 0 bit or on the one line (`tx_one_n`) for a 1 bit. The other line stays high, and the two lines are never low at the same time.
- R3: Each low pulse lasts W+1 clock cycles, where W is the 8-bit width value at address 2.
- R4: After every pulse, both lines stay high for G+1 cycles, where G is the 8-bit gap value at address 3. The next bit, or the end of the transfer, follows only after this gap.
- R5: Bits go out least-significant first, starting from data bit 0. Address 0 holds data bits 31:0 and address 1 holds bits 63:32.
- R6: Address 4 takes the bit count in wdata bits 6:0. A write with bit 7 set starts a transfer. A write with bit 7 clear only updates the count and produces no pulse. A count write always updates the register.
- R7: A count above 64 is stored and read back as 64, and a transfer with that count sends 64 bits.
- R8: The busy flag is 1 from the clock edge that accepts a start until the gap after the last bit ends, which is N*(W+G+2) cycles in total. A start written while busy is ignored, and the running transfer continues unchanged.
- R9: A bus access is acknowledged by `bus_ack` on the cycle after `bus_cyc` and `bus_stb` are both high. The acknowledge lasts one cycle, and read data is valid while it is high.
- R10: A start with a count of 0 sends nothing and leaves the busy flag at 0.
- R11: Writes to the data, width or gap registers during a transfer take effect in the registers but do not change the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Single-cycle acknowledge |
| tx_zero_n | output | 1 | Active-low line for zero bits |
| tx_one_n | output | 1 | Active-low line for one bits |

## Verification
The hardest case to reach from the ports is a register access that lands in the middle of a running transfer: a second start, a status read or a timing rewrite that arrives while pulses are being emitted. The bench's transfer routine captures both lines every cycle. At a chosen cycle inside the transfer window it injects one bus access and then compares the full waveform with a model computed from the requirements. This shows that the intruding access left the message intact, and that the busy flag reads 1 mid-transfer.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_PULSE = 2'd1,
    S_GAP   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/wgd_rst_sync.sv
module wgd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wgd_regs.sv
module wgd_regs #(
  parameter int DATA_W    = 64,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 3,
  parameter int SIZE_W    = 7,
  parameter int CNT_W     = 8,
  parameter int DEF_WIDTH = 4,
  parameter int DEF_GAP   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              busy_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  width_o,
  output logic [CNT_W-1:0]  gap_o,
  output logic [SIZE_W-1:0] start_size_o,
  output logic              start_o
);
  localparam int N_WORDS  = DATA_W / BUS_W;
  localparam int A_WIDTH  = N_WORDS;
  localparam int A_GAP    = N_WORDS + 1;
  localparam int A_SIZE   = N_WORDS + 2;
  localparam int A_STATUS = N_WORDS + 3;
  localparam int MAX_BITS = DATA_W;

  logic              ack_q;
  logic              req, wr, rd;
  logic [DATA_W-1:0] data_q, data_d;
  logic [CNT_W-1:0]  width_q, width_d, gap_q, gap_d;
  logic [SIZE_W-1:0] size_q, size_d, size_req;
  logic [BUS_W-1:0]  rdata_q, rdata_d;

  assign req = cyc_i & stb_i & ~ack_q;
  assign wr  = req & we_i;
  assign rd  = req & ~we_i;

  assign size_req = (wdata_i[SIZE_W-1:0] > SIZE_W'(MAX_BITS)) ?
                    SIZE_W'(MAX_BITS) : wdata_i[SIZE_W-1:0];

  // next-state logic for the data words
  always_comb begin
    data_d = data_q;
    for (int w = 0; w < N_WORDS; w++) begin
      if (wr && addr_i == ADDR_W'(w)) data_d[w*BUS_W +: BUS_W] = wdata_i;
    end
  end

  always_comb begin
    width_d = width_q;
    gap_d   = gap_q;
    size_d  = size_q;
    if (wr && addr_i == ADDR_W'(A_WIDTH)) width_d = wdata_i[CNT_W-1:0];
    if (wr && addr_i == ADDR_W'(A_GAP))   gap_d   = wdata_i[CNT_W-1:0];
    if (wr && addr_i == ADDR_W'(A_SIZE))  size_d  = size_req;
  end

  always_comb begin
    rdata_d = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (addr_i == ADDR_W'(w)) rdata_d = data_q[w*BUS_W +: BUS_W];
    end
    if (addr_i == ADDR_W'(A_WIDTH))  rdata_d = BUS_W'(width_q);
    if (addr_i == ADDR_W'(A_GAP))    rdata_d = BUS_W'(gap_q);
    if (addr_i == ADDR_W'(A_SIZE))   rdata_d = BUS_W'(size_q);
    if (addr_i == ADDR_W'(A_STATUS)) rdata_d = BUS_W'(busy_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      data_q  <= '0;
      width_q <= CNT_W'(DEF_WIDTH);
      gap_q   <= CNT_W'(DEF_GAP);
      size_q  <= '0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req;
      data_q  <= data_d;
      width_q <= width_d;
      gap_q   <= gap_d;
      size_q  <= size_d;
      if (rd) rdata_q <= rdata_d;
    end
  end

  assign start_o      = wr && (addr_i == ADDR_W'(A_SIZE)) && wdata_i[SIZE_W] && !busy_i;
  assign start_size_o = size_req;
  assign ack_o        = ack_q;
  assign rdata_o      = rdata_q;
  assign data_o       = data_q;
  assign width_o      = width_q;
  assign gap_o        = gap_q;

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R9
  AST_SIZE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    size_q <= SIZE_W'(MAX_BITS)); // R7
endmodule

// File: rtl/wgd_seq.sv
module wgd_seq
  import wgd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 7,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  gap_i,
  output logic              busy_o,
  output logic              zero_n_o,
  output logic              one_n_o
);
  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, wid_q, wid_d, gap_q, gap_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [SIZE_W-1:0] left_q, left_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wid_d   = wid_q;
    gap_d   = gap_q;
    shift_d = shift_q;
    left_d  = left_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i && size_i != '0) begin
          state_d = S_PULSE;
          cnt_d   = '0;
          shift_d = data_i;
          left_d  = size_i;
          wid_d   = width_i;
          gap_d   = gap_i;
        end
      end
      S_PULSE: begin
        if (cnt_q == wid_q) begin
          state_d = S_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_GAP: begin
        if (cnt_q == gap_q) begin
          cnt_d   = '0;
          shift_d = shift_q >> 1;
          left_d  = left_q - 1'b1;
          state_d = (left_q == SIZE_W'(1)) ? S_IDLE : S_PULSE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
      gap_q   <= '0;
      shift_q <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wid_q   <= wid_d;
      gap_q   <= gap_d;
      shift_q <= shift_d;
      left_q  <= left_d;
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign zero_n_o = !(state_q == S_PULSE && !shift_q[0]);
  assign one_n_o  = !(state_q == S_PULSE &&  shift_q[0]);

  AST_NO_DUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n_o || one_n_o)); // R2
  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE && cnt_q == wid_q) |=> (state_q == S_GAP)); // R3
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_GAP && cnt_q != gap_q) |=> (state_q == S_GAP && zero_n_o && one_n_o)); // R4
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (state_q == S_IDLE)); // R8
  AST_BUSY_HAS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (left_q != '0)); // R10
endmodule

// File: rtl/wgd_pulse_tx.sv
module wgd_pulse_tx #(
  parameter int DATA_W    = 64,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 3,
  parameter int SIZE_W    = 7,
  parameter int CNT_W     = 8,
  parameter int DEF_WIDTH = 4,
  parameter int DEF_GAP   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cyc,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic              tx_zero_n,
  output logic              tx_one_n
);
  logic              rst_n_s;
  logic              busy, start;
  logic [DATA_W-1:0] data;
  logic [CNT_W-1:0]  width, gap;
  logic [SIZE_W-1:0] start_size;

  wgd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s)
  );

  wgd_regs #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W),
    .CNT_W(CNT_W), .DEF_WIDTH(DEF_WIDTH), .DEF_GAP(DEF_GAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .cyc_i(bus_cyc), .stb_i(bus_stb), .we_i(bus_we),
    .addr_i(bus_addr), .wdata_i(bus_wdata), .busy_i(busy),
    .rdata_o(bus_rdata), .ack_o(bus_ack),
    .data_o(data), .width_o(width), .gap_o(gap),
    .start_size_o(start_size), .start_o(start)
  );

  wgd_seq #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .start_i(start), .size_i(start_size), .data_i(data),
    .width_i(width), .gap_i(gap),
    .busy_o(busy), .zero_n_o(tx_zero_n), .one_n_o(tx_one_n)
  );
endmodule

// File: tb/wgd_pulse_tx_bench.sv
`timescale 1ns/1ps
module wgd_pulse_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic        tx_zero_n, tx_one_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  wgd_pulse_tx u_wgd_pulse_tx (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .tx_zero_n(tx_zero_n), .tx_one_n(tx_one_n)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected line level: returns {zero_n, one_n}
  function automatic logic [1:0] exp_lines(int k, int n, int w, int g, logic [63:0] d);
    int p = w + g + 2;
    int j = k / p;
    int ph = k % p;
    if (j >= n || ph > w) return 2'b11;
    return d[j] ? 2'b10 : 2'b01;
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = a; bus_wdata = v;
    @(posedge clk);
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] v, output logic ackv);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    ackv = bus_ack; v = bus_rdata;
    bus_cyc = 0; bus_stb = 0;
  endtask

  // Start a transfer and watch both lines; optionally inject one bus access at cycle act_k.
  task automatic run_xfer(input int n_raw, input int n_exp, input int w, input int g,
                          input logic [63:0] d, input string tag,
                          input int act_k, input bit act_we, input logic [2:0] act_a,
                          input logic [31:0] act_v, output logic [31:0] act_rd);
    int total = n_exp * (w + g + 2);
    int bad = 0;
    logic [1:0] first_act = 2'b11, first_exp = 2'b11;
    logic [31:0] st;
    logic ak;
    act_rd = '0;
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_addr = 3'd4;
    bus_wdata = 32'(n_raw) | 32'h80;
    @(posedge clk);
    for (int k = 0; k < total + 4; k++) begin
      @(negedge clk);
      if (k == 0) begin bus_cyc = 0; bus_stb = 0; bus_we = 0; end
      if ({tx_zero_n, tx_one_n} !== exp_lines(k, n_exp, w, g, d)) begin
        if (bad == 0) begin
          first_act = {tx_zero_n, tx_one_n};
          first_exp = exp_lines(k, n_exp, w, g, d);
        end
        bad++;
      end
      if (act_k >= 2 && k == act_k + 1) begin
        act_rd = bus_rdata;
        bus_cyc = 0; bus_stb = 0; bus_we = 0;
      end
      if (act_k >= 2 && k == act_k) begin
        bus_cyc = 1; bus_stb = 1; bus_we = act_we; bus_addr = act_a; bus_wdata = act_v;
      end
    end
    check(bad == 0, tag, longint'(first_act), longint'(first_exp));
    bus_read(3'd5, st, ak);
    check(st[0] == 1'b0, {tag, " R8 busy clear after gap"}, st[0], 0);
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv, dummy;
    logic ak;
    logic [63:0] d;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(tx_zero_n === 1'b1 && tx_one_n === 1'b1, "R1 lines idle high", {tx_zero_n, tx_one_n}, 2'b11);
    bus_read(3'd5, rv, ak);
    check(rv[0] == 1'b0, "R1 busy clear", rv[0], 0);
    check(ak == 1'b1, "R9 ack one cycle after request", ak, 1);
    @(negedge clk);
    check(bus_ack == 1'b0, "R9 ack lasts one cycle", bus_ack, 0);
    bus_read(3'd2, rv, ak);
    check(rv == 32'd4, "R1 width default", rv, 4);
    bus_read(3'd3, rv, ak);
    check(rv == 32'd9, "R1 gap default", rv, 9);

    // R5 R2 R3 R4: directed pattern with default timing
    d = 64'h8000_0001_A5C3_0F96;
    bus_write(3'd0, d[31:0]);
    bus_write(3'd1, d[63:32]);
    run_xfer(12, 12, 4, 9, d, "R2 R3 R4 R5 default timing", -1, 0, 0, 0, dummy);

    // R3 R4 corner: zero width and zero gap
    bus_write(3'd2, 32'd0);
    bus_write(3'd3, 32'd0);
    run_xfer(64, 64, 0, 0, d, "R3 R4 zero width zero gap", -1, 0, 0, 0, dummy);

    // R7: count above limit is clamped
    bus_write(3'd2, 32'd1);
    bus_write(3'd3, 32'd2);
    run_xfer(100, 64, 1, 2, d, "R7 clamped length", -1, 0, 0, 0, dummy);
    bus_read(3'd4, rv, ak);
    check(rv == 32'd64, "R7 size reads back clamped", rv, 64);

    // R6: count write without start flag sends nothing
    bus_write(3'd4, 32'd5);
    begin
      int lows = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!tx_zero_n || !tx_one_n) lows++;
      end
      check(lows == 0, "R6 size write without start emits no pulse", lows, 0);
    end
    bus_read(3'd4, rv, ak);
    check(rv == 32'd5, "R6 size updated", rv, 5);
    bus_read(3'd5, rv, ak);
    check(rv[0] == 1'b0, "R6 no busy after plain size write", rv[0], 0);

    // R10: zero-length start
    bus_write(3'd4, 32'h80);
    begin
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!tx_zero_n || !tx_one_n) lows++;
      end
      check(lows == 0, "R10 zero count sends nothing", lows, 0);
    end
    bus_read(3'd5, rv, ak);
    check(rv[0] == 1'b0, "R10 busy stays clear", rv[0], 0);

    // R8: busy read mid-transfer
    bus_write(3'd2, 32'd2);
    bus_write(3'd3, 32'd3);
    run_xfer(6, 6, 2, 3, d, "R8 status read during transfer", 5, 0, 3'd5, 0, rv);
    check(rv[0] == 1'b1, "R8 busy set mid-transfer", rv[0], 1);

    // R8: second start while busy is ignored
    run_xfer(6, 6, 2, 3, d, "R8 start while busy ignored", 8, 1, 3'd4, 32'h80 | 32'd20, rv);
    bus_read(3'd4, rv, ak);
    check(rv == 32'd20, "R6 size updated by ignored start", rv, 20);

    // R11: width rewrite during a transfer affects only the next one
    run_xfer(5, 5, 2, 3, d, "R11 width write mid-transfer", 4, 1, 3'd2, 32'd7, rv);
    bus_read(3'd2, rv, ak);
    check(rv == 32'd7, "R11 width register took the write", rv, 7);
    run_xfer(3, 3, 7, 3, d, "R11 new width used next transfer", -1, 0, 0, 0, dummy);

    // random transfers
    for (int i = 0; i < 20; i++) begin
      int n = 1 + ($urandom % 64);
      int w = $urandom % 4;
      int g = $urandom % 4;
      logic [63:0] rd;
      rd = {$urandom, $urandom};
      bus_write(3'd0, rd[31:0]);
      bus_write(3'd1, rd[63:32]);
      bus_write(3'd2, 32'(w));
      bus_write(3'd3, 32'(g));
      run_xfer(n, n, w, g, rd, "R2 R3 R4 R5 random transfer", -1, 0, 0, 0, dummy);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule